// File: doc/BRIEF.md
# Configurable Fine-Grain Array Cell

This block is one cell of a symmetric array of small logic cells. The cell has an A input and a B input from each of its four neighbours, and it touches the four local bus wires that run through it. Two of those wires run vertically (V1, V2) and two run horizontally (H1, H2). Static configuration inputs set the cell up. They choose which neighbour feeds each side, what gates each side, which of four function states drives the two outputs, and which buses the cell reads, writes or turns. One A output and one B output go to all four neighbours.

Each side has an input selector. Its output is ANDed with a second operand, which is either a constant or a value read from a bus. The two AND results, called left and right, are routed by two output selectors that always share one state code. In the registered state, a flip-flop stores the XOR of left and right. The flip-flop is clocked by the column clock and cleared asynchronously by the column reset. Bus traffic leaves the cell as a per-wire drive enable with a data value, not as a true tristate. The cell flags any configuration that puts one wire into more than one operation, and while it does so it drives no bus.

Top module: `fgcell`

## Requirements
- R1: Side selection. For each side, a source code of 0..3 selects neighbour N, E, S or W from bit 0..3 of that side's neighbour vector. Any code of 4..7 selects a constant 1.
- R2: Second AND operand. The operand code is 0 for constant 1, 1 for constant 0, 2 for the pair's vertical wire and 3 for the pair's horizontal wire. The left AND uses pair 0 (bus bit 0 = V1, bit 1 = H1). The right AND uses pair 1 (bus bit 2 = V2, bit 3 = H2). Codes 2 and 3 count as a read of that wire.
- R3: State code 0 gives a_out = left and b_out = right.
- R4: State code 1 gives a_out = right and b_out = left.
- R5: State code 2 gives a_out = left XOR right and b_out = NOT(left AND right).
- R6: The flip-flop loads left XOR right on every rising column clock edge. State code 3 gives a_out = stored value and b_out = left AND right.
- R7: While col_rst_n is low, the stored value is 0. The clear takes effect at once, without a clock edge.
- R8: Setting cfg_wr bit i enables a drive on wire i. The drive data is a_out for wires 0 and 1 and b_out for wires 2 and 3. With cfg_wr_gated set, a write drives only while the selected B-side value is 1.
- R9: cfg_turn bit p links pair p. With cfg_turn_dir bit p at 0, the vertical wire's value is driven onto the horizontal wire. At 1, the horizontal wire's value is driven onto the vertical wire. A turn uses both wires of the pair.
- R10: cfg_err is 1 exactly when some wire has more than one use among read, write and turn. While cfg_err is 1, all drive enables are 0. bus_drv_data is 0 on every wire whose enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| col_clk | input | 1 | Column clock for the cell flip-flop |
| col_rst_n | input | 1 | Column asynchronous clear, active low |
| nbr_a_in | input | 4 | A inputs from neighbours N, E, S, W (bits 0..3) |
| nbr_b_in | input | 4 | B inputs from neighbours N, E, S, W (bits 0..3) |
| bus_in | input | 4 | Current values of V1, H1, V2, H2 |
| cfg_a_src | input | 3 | A-side source code |
| cfg_b_src | input | 3 | B-side source code |
| cfg_l_op | input | 2 | Left AND second-operand code |
| cfg_r_op | input | 2 | Right AND second-operand code |
| cfg_state | input | 2 | Function state code |
| cfg_wr | input | 4 | Per-wire write enables |
| cfg_wr_gated | input | 1 | Gate writes with the B-side value |
| cfg_turn | input | 2 | Per-pair turn enables |
| cfg_turn_dir | input | 2 | Per-pair turn direction |
| a_out | output | 1 | A output to all neighbours |
| b_out | output | 1 | B output to all neighbours |
| bus_drv_en | output | 4 | Per-wire drive request |
| bus_drv_data | output | 4 | Per-wire drive value |
| cfg_err | output | 1 | Bus-use conflict flag |

## Verification
Apart from the flip-flop, everything in the cell is combinational. A wrong selector setting or a wrong output routing therefore shows on a_out, b_out or the bus drives in the same cycle as the input pattern that exposes it. A flip-flop that loads the wrong value, or misses its clear, shows on a_out in state 3 from the first edge after the fault. The conflict logic is compared against a per-wire use count in every cycle. This includes clean configurations, where a false error flag would silence drives that should be active.

// File: rtl/fgcell_pkg.sv
package fgcell_pkg;
  localparam int NNBR   = 4;
  localparam int NBUS   = 4;
  localparam int NPAIR  = NBUS / 2;
  localparam int SRC_W  = $clog2(NNBR) + 1;
  localparam int OP_W   = 2;
  localparam int ST_W   = 2;

  localparam logic [OP_W-1:0] OP_ONE  = 2'd0;
  localparam logic [OP_W-1:0] OP_ZERO = 2'd1;
  localparam logic [OP_W-1:0] OP_VBUS = 2'd2;
  localparam logic [OP_W-1:0] OP_HBUS = 2'd3;

  typedef enum logic [ST_W-1:0] {
    ST_PASS  = 2'd0,
    ST_SWAP  = 2'd1,
    ST_LOGIC = 2'd2,
    ST_REG   = 2'd3
  } fstate_e;
endpackage

// File: rtl/fgcell_insel.sv
module fgcell_insel #(
  parameter int N  = 4,
  parameter int SW = $clog2(N) + 1
) (
  input  logic [N-1:0]  src,
  input  logic [SW-1:0] sel,
  output logic          val
);
  localparam int IW = SW - 1;

  always_comb begin
    if (sel[SW-1]) val = 1'b1;
    else           val = src[sel[IW-1:0]];
  end
endmodule

// File: rtl/fgcell_func.sv
module fgcell_func
  import fgcell_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            left,
  input  logic            right,
  input  logic [ST_W-1:0] state,
  output logic            a,
  output logic            b
);
  logic q;
  logic x;

  assign x = left ^ right;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= x;
  end

  always_comb begin
    unique case (fstate_e'(state))
      ST_PASS:  begin a = left;  b = right;           end
      ST_SWAP:  begin a = right; b = left;            end
      ST_LOGIC: begin a = x;     b = ~(left & right); end
      default:  begin a = q;     b = left & right;    end
    endcase
  end

  // R5
  xor_nand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && a) |-> b);

  // R6
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q == $past(left ^ right));

  // R7
  reg_clear_chk: assert property (@(posedge clk) !rst_n |-> !q);
endmodule

// File: rtl/fgcell_busctl.sv
module fgcell_busctl
  import fgcell_pkg::*;
(
  input  logic [NBUS-1:0]  bus_in,
  input  logic [NBUS-1:0]  rd_use,
  input  logic [NBUS-1:0]  wr,
  input  logic             wr_gated,
  input  logic             gate_val,
  input  logic             a_val,
  input  logic             b_val,
  input  logic [NPAIR-1:0] turn,
  input  logic [NPAIR-1:0] turn_dir,
  output logic [NBUS-1:0]  drv_en,
  output logic [NBUS-1:0]  drv_data,
  output logic             err
);
  logic [NBUS-1:0] clash;
  logic [NBUS-1:0] raw_en;
  logic [NBUS-1:0] raw_data;
  logic            gate;

  assign gate = wr_gated ? gate_val : 1'b1;

  for (genvar i = 0; i < NBUS; i++) begin : g_wire
    localparam int P = i / 2;
    localparam bit IS_H = (i % 2) == 1;
    logic [1:0] uses;
    logic       t_tgt;
    assign uses  = {1'b0, rd_use[i]} + {1'b0, wr[i]} + {1'b0, turn[P]};
    assign clash[i] = uses > 2'd1;
    assign t_tgt = turn[P] && (IS_H ? !turn_dir[P] : turn_dir[P]);
    always_comb begin
      if (t_tgt) begin
        raw_en[i]   = 1'b1;
        raw_data[i] = bus_in[IS_H ? i - 1 : i + 1];
      end else begin
        raw_en[i]   = wr[i] & gate;
        raw_data[i] = (P == 0) ? a_val : b_val;
      end
    end
  end

  assign err      = |clash;
  assign drv_en   = err ? '0 : raw_en;
  assign drv_data = drv_en & raw_data;

  // R8
  always_comb begin
    if (!err && !wr_gated)
      wr_drive_chk: assert ((wr & ~drv_en) == '0);
  end
endmodule

// File: rtl/fgcell.sv
module fgcell
  import fgcell_pkg::*;
(
  input  logic                col_clk,
  input  logic                col_rst_n,
  input  logic [NNBR-1:0]     nbr_a_in,
  input  logic [NNBR-1:0]     nbr_b_in,
  input  logic [NBUS-1:0]     bus_in,
  input  logic [SRC_W-1:0]    cfg_a_src,
  input  logic [SRC_W-1:0]    cfg_b_src,
  input  logic [OP_W-1:0]     cfg_l_op,
  input  logic [OP_W-1:0]     cfg_r_op,
  input  logic [ST_W-1:0]     cfg_state,
  input  logic [NBUS-1:0]     cfg_wr,
  input  logic                cfg_wr_gated,
  input  logic [NPAIR-1:0]    cfg_turn,
  input  logic [NPAIR-1:0]    cfg_turn_dir,
  output logic                a_out,
  output logic                b_out,
  output logic [NBUS-1:0]     bus_drv_en,
  output logic [NBUS-1:0]     bus_drv_data,
  output logic                cfg_err
);
  logic                 a_sel, b_sel;
  logic [NPAIR-1:0]     side_val;
  logic [NPAIR-1:0]     and_out;
  logic [OP_W-1:0]      op [NPAIR];
  logic [NBUS-1:0]      rd_use;

  fgcell_insel #(.N(NNBR), .SW(SRC_W)) u_asel (
    .src(nbr_a_in), .sel(cfg_a_src), .val(a_sel));
  fgcell_insel #(.N(NNBR), .SW(SRC_W)) u_bsel (
    .src(nbr_b_in), .sel(cfg_b_src), .val(b_sel));

  assign side_val[0] = a_sel;
  assign side_val[1] = b_sel;
  assign op[0] = cfg_l_op;
  assign op[1] = cfg_r_op;

  for (genvar p = 0; p < NPAIR; p++) begin : g_side
    logic opnd;
    always_comb begin
      unique case (op[p])
        OP_ONE:  opnd = 1'b1;
        OP_ZERO: opnd = 1'b0;
        OP_VBUS: opnd = bus_in[2*p];
        default: opnd = bus_in[2*p+1];
      endcase
    end
    assign and_out[p]    = side_val[p] & opnd;
    assign rd_use[2*p]   = op[p] == OP_VBUS;
    assign rd_use[2*p+1] = op[p] == OP_HBUS;
  end

  fgcell_func u_func (
    .clk(col_clk), .rst_n(col_rst_n),
    .left(and_out[0]), .right(and_out[1]),
    .state(cfg_state), .a(a_out), .b(b_out));

  fgcell_busctl u_bus (
    .bus_in(bus_in), .rd_use(rd_use), .wr(cfg_wr),
    .wr_gated(cfg_wr_gated), .gate_val(b_sel),
    .a_val(a_out), .b_val(b_out),
    .turn(cfg_turn), .turn_dir(cfg_turn_dir),
    .drv_en(bus_drv_en), .drv_data(bus_drv_data), .err(cfg_err));

  // R10
  conflict_quiet_chk: assert property (@(posedge col_clk) disable iff (!col_rst_n)
    cfg_err |-> bus_drv_en == '0);

  // R3
  route_pop_chk: assert property (@(posedge col_clk) disable iff (!col_rst_n)
    cfg_state[1] == 1'b0 |-> $countones({a_out, b_out}) == $countones(and_out));
endmodule

// File: tb/sim_fgcell.sv
`timescale 1ns/100ps
module sim_fgcell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] na = '0, nb = '0, bus = '0;
  logic [2:0] asrc = '0, bsrc = '0;
  logic [1:0] lop = '0, rop = '0, st = '0;
  logic [3:0] wr = '0;
  logic       gated = 1'b0;
  logic [1:0] turn = '0, tdir = '0;
  logic       a_out, b_out, err;
  logic [3:0] den, ddat;

  int checks = 0;
  int errors = 0;
  logic ref_q = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  fgcell u0 (
    .col_clk(clk), .col_rst_n(rst_n), .nbr_a_in(na), .nbr_b_in(nb),
    .bus_in(bus), .cfg_a_src(asrc), .cfg_b_src(bsrc), .cfg_l_op(lop),
    .cfg_r_op(rop), .cfg_state(st), .cfg_wr(wr), .cfg_wr_gated(gated),
    .cfg_turn(turn), .cfg_turn_dir(tdir), .a_out(a_out), .b_out(b_out),
    .bus_drv_en(den), .bus_drv_data(ddat), .cfg_err(err));

  function automatic logic side(input logic [3:0] v, input logic [2:0] s);
    if (s >= 3'd4) return 1'b1;
    return v[s];
  endfunction

  function automatic logic opnd(input logic [1:0] o, input logic v, input logic h);
    case (o)
      2'd0: return 1'b1;
      2'd1: return 1'b0;
      2'd2: return v;
      default: return h;
    endcase
  endfunction

  logic e_a, e_b, e_err;
  logic [3:0] e_en, e_dat;
  string st_tag;

  task automatic model();
    logic av, bv, l, r, g;
    int use_cnt [4];
    av = side(na, asrc);
    bv = side(nb, bsrc);
    l = av & opnd(lop, bus[0], bus[1]);
    r = bv & opnd(rop, bus[2], bus[3]);
    case (st)
      2'd0: begin e_a = l; e_b = r; st_tag = "R3"; end
      2'd1: begin e_a = r; e_b = l; st_tag = "R4"; end
      2'd2: begin e_a = l ^ r; e_b = !(l && r); st_tag = "R5"; end
      default: begin e_a = ref_q; e_b = l & r; st_tag = "R6"; end
    endcase
    for (int i = 0; i < 4; i++) use_cnt[i] = 0;
    if (lop == 2'd2) use_cnt[0]++;
    if (lop == 2'd3) use_cnt[1]++;
    if (rop == 2'd2) use_cnt[2]++;
    if (rop == 2'd3) use_cnt[3]++;
    for (int i = 0; i < 4; i++) begin
      if (wr[i]) use_cnt[i]++;
      if (turn[i/2]) use_cnt[i]++;
    end
    e_err = 1'b0;
    for (int i = 0; i < 4; i++) if (use_cnt[i] > 1) e_err = 1'b1;
    g = gated ? bv : 1'b1;
    e_en = '0; e_dat = '0;
    for (int i = 0; i < 4; i++) if (wr[i] && g) begin
      e_en[i] = 1'b1; e_dat[i] = (i < 2) ? e_a : e_b;
    end
    for (int p = 0; p < 2; p++) if (turn[p]) begin
      if (!tdir[p]) begin e_en[2*p+1] = 1'b1; e_dat[2*p+1] = bus[2*p]; end
      else          begin e_en[2*p]   = 1'b1; e_dat[2*p]   = bus[2*p+1]; end
    end
    if (e_err) begin e_en = '0; e_dat = '0; end
  endtask

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    model();
    chk(st_tag, {3'b0, a_out}, {3'b0, e_a});
    chk(st_tag, {3'b0, b_out}, {3'b0, e_b});
    chk("R10 flag", {3'b0, err}, {3'b0, e_err});
    chk("R8 R9 R10 enable", den, e_en);
    chk("R8 R9 data", ddat, e_dat);
  endtask

  // reference register: R6 load, R7 clear
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else ref_q <= side(na, asrc) & opnd(lop, bus[0], bus[1])
                ^ side(nb, bsrc) & opnd(rop, bus[2], bus[3]);
  end

  task automatic clean_cfg();
    turn = 2'($urandom);
    tdir = 2'($urandom);
    wr = 4'($urandom);
    lop = 2'($urandom);
    rop = 2'($urandom);
    if (turn[0]) begin wr[1:0] = 2'b00; lop = 2'($urandom % 2); end
    else begin
      if (lop == 2'd2) wr[0] = 1'b0;
      if (lop == 2'd3) wr[1] = 1'b0;
    end
    if (turn[1]) begin wr[3:2] = 2'b00; rop = 2'($urandom % 2); end
    else begin
      if (rop == 2'd2) wr[2] = 1'b0;
      if (rop == 2'd3) wr[3] = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state
    @(negedge clk); @(negedge clk);
    st = 2'd3; #2; check_all();
    chk("R7 reset", {3'b0, a_out}, 4'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R2 directed: constant sources
    st = 2'd0; asrc = 3'd5; lop = 2'd0; #1;
    chk("R1 const one", {3'b0, a_out}, 4'd1);
    lop = 2'd1; #1;
    chk("R2 const zero", {3'b0, a_out}, 4'd0);
    asrc = 3'd2; na = 4'b0100; lop = 2'd0; #1;
    chk("R1 south select", {3'b0, a_out}, 4'd1);
    lop = 2'd3; bus = 4'b0000; #1;
    chk("R2 horizontal read", {3'b0, a_out}, 4'd0);

    // R7 asynchronous clear mid-cycle
    @(negedge clk); st = 2'd3; asrc = 3'd4; lop = 2'd0; bsrc = 3'd4; rop = 2'd1;
    @(negedge clk); @(negedge clk);
    chk("R6 stored one", {3'b0, a_out}, 4'd1);
    #1 rst_n = 1'b0; #0.5;
    chk("R7 async clear", {3'b0, a_out}, 4'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (n % 8 == 0) begin
        asrc = 3'($urandom); bsrc = 3'($urandom); st = 2'($urandom);
        gated = 1'($urandom);
        if (n % 16 == 0) clean_cfg();
        else begin
          lop = 2'($urandom); rop = 2'($urandom); wr = 4'($urandom);
          turn = 2'($urandom); tdir = 2'($urandom);
        end
      end
      na = 4'($urandom); nb = 4'($urandom); bus = 4'($urandom);
      #2;
      check_all();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule